// File: doc/BRIEF.md
# Outstanding Command Byte Tracker

This block keeps a small table of memory commands that are still in flight. A requester reserves a slot by presenting the total number of bytes the command must move and a tag of its own choosing. The block picks a free slot, loads the byte total and returns the slot index, which the requester then uses as the identifier on its DMA requests.

The DMA engine reports progress as a stream of partial completions. Each one carries a slot identifier and the number of bytes just finished. The block subtracts those bytes from the slot's remaining count. When a slot's count is used up, it issues a one-cycle completion that carries the stored tag, and it frees the slot. A full flag tells requesters to stall when no slot is free. A sticky error flag records any progress report that names a slot not in use.

Top module: `cmd_byte_tracker`

## Requirements
- R1: After reset every slot is free, `full` and `done_valid` and `err` are 0, and `alloc_ready` is 1.
- R2: `alloc_id` always shows the lowest-numbered free slot. An allocation is taken at a clock edge when `alloc_valid` and `alloc_ready` are both 1, and the slot then holds `alloc_bytes` and `alloc_tag`.
- R3: `full` is 1 exactly when every slot is in use, and `alloc_ready` is its inverse. An `alloc_valid` raised while `full` is 1 changes no slot.
- R4: A progress report (`rsp_valid`=1) naming an in-use slot, with `rsp_bytes` below that slot's remaining count, lowers the count by `rsp_bytes`. No completion is produced.
- R5: A progress report with `rsp_bytes` at or above the remaining count ends the slot. In the next cycle only, `done_valid`=1, `done_tag` holds the stored tag and `done_id` holds the slot index.
- R6: A slot that ends is free in the cycle of its `done_valid` pulse. `full` drops in that same cycle, so the slot can be allocated again at once.
- R7: An allocation and a progress report that fall in the same cycle both take effect.
- R8: A progress report naming a free slot changes no slot and sets `err`. `err` stays 1 until reset.
- R9: A command ends only after the sum of its progress reports reaches its allocated byte total, whatever the number of reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to reserve a slot |
| alloc_bytes | input | BYTES_W | Total bytes of the new command |
| alloc_tag | input | TAG_W | Caller tag stored with the command |
| alloc_ready | output | 1 | A slot is free (allocation will be taken) |
| alloc_id | output | IDX_W | Index of the slot an allocation would take |
| rsp_valid | input | 1 | DMA progress report present |
| rsp_id | input | IDX_W | Slot named by the report |
| rsp_bytes | input | BYTES_W | Bytes finished by this report |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | TAG_W | Tag of the completed command |
| done_id | output | IDX_W | Slot of the completed command |
| full | output | 1 | No slot is free |
| err | output | 1 | Sticky flag: a report named a free slot |

## Verification
The allocation path and the progress path can act in the same clock cycle. They act on different slots, and a completion can free a slot in the very cycle after another one was reserved. The bench provokes this in two ways. In directed cycles it raises both `alloc_valid` and `rsp_valid`, with the report ending a different slot. It also runs a long random phase where both arrive often and independently. A behavioural model holds per-slot counts in plain integers and predicts `alloc_id`, `full`, the completion outputs and `err` for every cycle. Each prediction is compared against the ports, so a lost allocation, a lost decrement or a wrongly freed slot shows up as a mismatch.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int unsigned CBT_DEF_SLOTS   = 4;
  localparam int unsigned CBT_DEF_BYTES_W = 16;
  localparam int unsigned CBT_DEF_TAG_W   = 8;
endpackage

// File: rtl/cbt_free_pick.sv
module cbt_free_pick #(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0] busy_vec,
  output logic             any_free,
  output logic [IDX_W-1:0] pick_idx
);
  always_comb begin
    any_free = 1'b0;
    pick_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!busy_vec[i]) begin
        any_free = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cbt_slot.sv
module cbt_slot #(
  parameter int unsigned BYTES_W = 16,
  parameter int unsigned TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [BYTES_W-1:0] load_bytes,
  input  logic [TAG_W-1:0]   load_tag,
  input  logic               rsp_hit,
  input  logic [BYTES_W-1:0] rsp_bytes,
  output logic               busy,
  output logic [TAG_W-1:0]   tag,
  output logic               drain
);
  logic               busy_q, busy_d;
  logic [BYTES_W-1:0] remain_q, remain_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic               upd_en;

  assign drain  = rsp_hit && busy_q && (rsp_bytes >= remain_q);
  assign upd_en = load_en || (rsp_hit && busy_q);

  always_comb begin
    busy_d   = busy_q;
    remain_d = remain_q;
    tag_d    = tag_q;
    if (load_en) begin
      busy_d   = 1'b1;
      remain_d = load_bytes;
      tag_d    = load_tag;
    end else if (drain) begin
      busy_d   = 1'b0;
      remain_d = '0;
    end else if (rsp_hit && busy_q) begin
      remain_d = remain_q - rsp_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      tag_q    <= '0;
    end else if (upd_en) begin
      busy_q   <= busy_d;
      remain_q <= remain_d;
      tag_q    <= tag_d;
    end
  end

  assign busy = busy_q;
  assign tag  = tag_q;

  // R2
  load_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !busy_q);
  // R4
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rsp_hit && !load_en) |=> (busy_q && $stable(remain_q)));
  // R9
  partial_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rsp_hit && (rsp_bytes < remain_q)) |=> busy_q);
endmodule

// File: rtl/cmd_byte_tracker.sv
module cmd_byte_tracker
  import cbt_pkg::*;
#(
  parameter int unsigned SLOTS   = CBT_DEF_SLOTS,
  parameter int unsigned BYTES_W = CBT_DEF_BYTES_W,
  parameter int unsigned TAG_W   = CBT_DEF_TAG_W,
  localparam int unsigned IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [BYTES_W-1:0] alloc_bytes,
  input  logic [TAG_W-1:0]   alloc_tag,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_id,
  input  logic               rsp_valid,
  input  logic [IDX_W-1:0]   rsp_id,
  input  logic [BYTES_W-1:0] rsp_bytes,
  output logic               done_valid,
  output logic [TAG_W-1:0]   done_tag,
  output logic [IDX_W-1:0]   done_id,
  output logic               full,
  output logic               err
);
  logic [SLOTS-1:0] busy_vec, drain_vec, load_vec, hit_vec;
  logic [TAG_W-1:0] tag_arr [SLOTS];
  logic             any_free, alloc_fire, rsp_to_busy;

  cbt_free_pick #(.SLOTS(SLOTS)) u_pick (
    .busy_vec (busy_vec),
    .any_free (any_free),
    .pick_idx (alloc_id)
  );

  assign full        = !any_free;
  assign alloc_ready = any_free;
  assign alloc_fire  = alloc_valid && any_free;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign load_vec[g] = alloc_fire && (alloc_id == IDX_W'(g));
    assign hit_vec[g]  = rsp_valid && (rsp_id == IDX_W'(g));
    cbt_slot #(.BYTES_W(BYTES_W), .TAG_W(TAG_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (load_vec[g]),
      .load_bytes (alloc_bytes),
      .load_tag   (alloc_tag),
      .rsp_hit    (hit_vec[g]),
      .rsp_bytes  (rsp_bytes),
      .busy       (busy_vec[g]),
      .tag        (tag_arr[g]),
      .drain      (drain_vec[g])
    );
  end

  assign rsp_to_busy = |(hit_vec & busy_vec);

  logic             dv_q, dv_d, err_q, err_d;
  logic [TAG_W-1:0] dt_q, dt_d;
  logic [IDX_W-1:0] di_q, di_d;

  always_comb begin
    dv_d  = |drain_vec;
    dt_d  = '0;
    di_d  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (drain_vec[i]) begin
        dt_d = dt_d | tag_arr[i];
        di_d = di_d | IDX_W'(i);
      end
    end
    err_d = err_q || (rsp_valid && !rsp_to_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      dt_q  <= '0;
      di_q  <= '0;
      err_q <= 1'b0;
    end else begin
      dv_q  <= dv_d;
      err_q <= err_d;
      if (dv_d) begin
        dt_q <= dt_d;
        di_q <= di_d;
      end
    end
  end

  assign done_valid = dv_q;
  assign done_tag   = dt_q;
  assign done_id    = di_q;
  assign err        = err_q;

  // R5
  one_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drain_vec));
  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(rsp_valid));
  // R6
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy_vec[done_id]);
  // R2
  alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> busy_vec[$past(alloc_id)]);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rsp_valid) |=> full);
endmodule

// File: tb/cmd_byte_tracker_bench.sv
`timescale 1ns/1ps
module cmd_byte_tracker_bench;
  localparam int N  = 4;
  localparam int BW = 16;
  localparam int TW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_valid, rsp_valid;
  logic [BW-1:0] alloc_bytes, rsp_bytes;
  logic [TW-1:0] alloc_tag;
  logic [IW-1:0] rsp_id;
  logic          alloc_ready, done_valid, full, err;
  logic [IW-1:0] alloc_id, done_id;
  logic [TW-1:0] done_tag;

  always #2 clk = ~clk;

  cmd_byte_tracker #(.SLOTS(N), .BYTES_W(BW), .TAG_W(TW)) u_cmd_byte_tracker (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_bytes(alloc_bytes), .alloc_tag(alloc_tag),
    .alloc_ready(alloc_ready), .alloc_id(alloc_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_bytes(rsp_bytes),
    .done_valid(done_valid), .done_tag(done_tag), .done_id(done_id),
    .full(full), .err(err)
  );

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;
  bit  m_busy [N];
  int  m_rem  [N];
  int  m_tag  [N];
  bit  m_dv, m_err;
  int  m_dt, m_di;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int m_free();
    for (int i = N - 1; i >= 0; i--) if (!m_busy[i]) m_free = i;
    if (m_busy[0] && m_busy[1] && m_busy[2] && m_busy[3]) m_free = 0;
  endfunction

  function automatic bit m_full();
    m_full = 1;
    for (int i = 0; i < N; i++) if (!m_busy[i]) m_full = 0;
  endfunction

  task automatic compare(string scen);
    chk({"R2 ", scen}, "alloc_id", int'(alloc_id), m_free());
    chk({"R3 ", scen}, "full", int'(full), int'(m_full()));
    chk({"R3 ", scen}, "alloc_ready", int'(alloc_ready), int'(!m_full()));
    chk({"R5 ", scen}, "done_valid", int'(done_valid), int'(m_dv));
    if (m_dv) begin
      chk({"R5 ", scen}, "done_tag", int'(done_tag), m_dt);
      chk({"R5 ", scen}, "done_id", int'(done_id), m_di);
    end
    chk({"R8 ", scen}, "err", int'(err), int'(m_err));
  endtask

  // one cycle: drive at negedge, compare, advance model and clock
  task automatic cyc(string scen, bit av, int ab, int at, bit rv, int rid, int rb);
    int fi;
    bit fl;
    alloc_valid = av; alloc_bytes = BW'(ab); alloc_tag = TW'(at);
    rsp_valid = rv; rsp_id = IW'(rid); rsp_bytes = BW'(rb);
    #1;
    compare(scen);
    fi = m_free();
    fl = m_full();
    m_dv = 0;
    if (rv) begin
      if (m_busy[rid]) begin
        if (rb >= m_rem[rid]) begin
          m_busy[rid] = 0; m_dv = 1; m_dt = m_tag[rid]; m_di = rid;
        end else m_rem[rid] = m_rem[rid] - rb;
      end else m_err = 1;
    end
    if (av && !fl) begin
      m_busy[fi] = 1; m_rem[fi] = ab; m_tag[fi] = at;
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    alloc_valid = 0; alloc_bytes = '0; alloc_tag = '0;
    rsp_valid = 0; rsp_id = '0; rsp_bytes = '0;
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_rem[i] = 0; m_tag[i] = 0; end
    m_dv = 0; m_err = 0; m_dt = 0; m_di = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1", "full", int'(full), 0);
    chk("R1", "alloc_ready", int'(alloc_ready), 1);
    chk("R1", "done_valid", int'(done_valid), 0);
    chk("R1", "err", int'(err), 0);
    @(negedge clk);
    rst_n = 1;
    // R2 fill all slots in order
    cyc("R2 fill", 1, 64, 'hA0, 0, 0, 0);
    cyc("R2 fill", 1, 32, 'hA1, 0, 0, 0);
    cyc("R2 fill", 1, 16, 'hA2, 0, 0, 0);
    cyc("R2 fill", 1,  8, 'hA3, 0, 0, 0);
    // R3 alloc while full is ignored
    cyc("R3 full", 1, 5, 'hEE, 0, 0, 0);
    cyc("R3 full", 0, 0, 0, 0, 0, 0);
    // R4 R9 partial reports on slot 1
    cyc("R4 part", 0, 0, 0, 1, 1, 10);
    cyc("R9 part", 0, 0, 0, 1, 1, 10);
    cyc("R9 last", 0, 0, 0, 1, 1, 12);
    // R6 reallocate in the done cycle
    cyc("R6 realloc", 1, 20, 'hB1, 0, 0, 0);
    cyc("R6 after", 0, 0, 0, 0, 0, 0);
    // free slot 2 (overshoot), then R7 alloc plus report together
    cyc("R5 over", 0, 0, 0, 1, 2, 100);
    cyc("R7 same", 1, 7, 'hC2, 1, 0, 64);
    cyc("R7 same", 1, 9, 'hC0, 1, 3, 3);
    cyc("R7 check", 0, 0, 0, 1, 3, 5);
    cyc("R7 check", 0, 0, 0, 0, 0, 0);
    // R8 report to free slot 3
    cyc("R8 bad", 0, 0, 0, 1, 3, 1);
    cyc("R8 sticky", 0, 0, 0, 0, 0, 0);
    cyc("R8 sticky", 0, 0, 0, 0, 0, 0);
    // random phase covering R4 R5 R7 R9
    for (int k = 0; k < 3000; k++) begin
      cyc("R7 rand", bit'($urandom_range(0, 1)), int'($urandom_range(1, 40)),
          int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
          int'($urandom_range(0, N - 1)), int'($urandom_range(1, 24)));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule